// File: doc/BRIEF.md
# Core Clock Pause and Clock-Output Selector

This block controls whether the processor core advances. It does not gate a real clock. It produces a registered clock-enable, `core_en`. Two controls can pause the core, and they act identically: an asynchronous active-low pause pin and a software no-clock bit. Every core register qualified by `core_en` holds its value while paused. When the pause is released, execution resumes from exactly that state.

The block also drives one programmable clock-output pin. Software picks the source with a 3-bit field. The five sources are:
- a free-running image of the internal clock;
- a standby-aware copy of that clock, forced high while the core waits in low-power standby;
- an image of the reference input clock, derived by dividing the simulation clock by `REF_DIV`;
- constant 0;
- constant 1.

Clock images are toggle registers, so every source is ordinary synchronous data. All controls are plain level pins and no data stream passes through the block, so there is no valid/ready interface.

Top module: `clk_pause_ctl`

## Requirements
- R1: While `rst_n` is low, `core_en` is 1. The internal and reference images are both 0, so `clk_out` is 0 for select codes 0 and 2.
- R2: The pause pin passes through a two-stage synchronizer. Suppose `pause_n` falls before rising edge 1. Then `core_en` is first 0 after rising edge 3.
- R3: Suppose `pause_n` is held low for L rising edges and then returns high. Then `core_en` is low for exactly L cycles and afterwards returns to 1. A counter enabled by `core_en` loses no counts other than those L.
- R4: Setting `nock` drives `core_en` to 0 after the next rising edge, and clearing it restores 1 one edge later. `core_en` is 1 only when neither `nock` nor the synchronized pause is active.
- R5: Select code 0 gives the internal image. After k rising edges out of reset it equals k mod 2. It keeps toggling while the core is paused.
- R6: Select code 1 gives the standby-aware image. It is 1 while `standby` is high and otherwise equals the code 0 value.
- R7: Select code 2 gives the reference image, equal to floor(k / REF_DIV) mod 2 after k edges.
- R8: Select code 3 and the unused codes 5, 6 and 7 give 0. Code 4 gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation clock, standing for both the internal and input clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| pause_n | input | 1 | Asynchronous active-low pause pin |
| nock | input | 1 | Software no-clock control bit, active high |
| standby | input | 1 | Low-power wait flag |
| osel | input | 3 | Clock-output source select |
| core_en | output | 1 | Registered core clock-enable |
| clk_out | output | 1 | Selected clock-output source |

## Verification
The assertions assume that `nock`, `standby` and `osel` change only away from the rising edge, as register outputs would. They make no such assumption about `pause_n`. That pin is checked only after the synchronizer, so its latency assertions rest on the synchronizer output rather than the raw pin. The bench drives every input on the falling edge and samples on the falling edge. It sweeps pause lengths 1 to 6, every select code with standby both low and high, and overlapping pause and no-clock windows.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    OSEL_CLK   = 3'd0,
    OSEL_GATED = 3'd1,
    OSEL_REF   = 3'd2,
    OSEL_LO    = 3'd3,
    OSEL_HI    = 3'd4
  } osel_e;
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cpc_phase.sv
module cpc_phase #(
  parameter int REF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic int_ph,
  output logic ref_ph
);
  localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  always_ff @(posedge clk) begin
    if (!rst_n) int_ph <= 1'b0;
    else        int_ph <= ~int_ph;
  end

  // R5
  int_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> int_ph != $past(int_ph));

  generate
    if (REF_DIV == 1) begin : g_same
      assign ref_ph = int_ph;
    end else begin : g_div
      logic [CW-1:0] cnt;
      logic          ph;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
          ph  <= 1'b0;
        end else if (cnt == CW'(REF_DIV - 1)) begin
          cnt <= '0;
          ph  <= ~ph;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign ref_ph = ph;
    end
  endgenerate
endmodule

// File: rtl/cpc_outsel.sv
module cpc_outsel
  import cpc_pkg::*;
(
  input  logic             int_ph,
  input  logic             ref_ph,
  input  logic             standby,
  input  logic [SEL_W-1:0] sel,
  output logic             pin
);
  always_comb begin
    case (sel)
      OSEL_CLK:   pin = int_ph;
      OSEL_GATED: pin = int_ph | standby;
      OSEL_REF:   pin = ref_ph;
      OSEL_HI:    pin = 1'b1;
      default:    pin = 1'b0;
    endcase
  end
endmodule

// File: rtl/clk_pause_ctl.sv
module clk_pause_ctl
  import cpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_DIV     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pause_n,
  input  logic             nock,
  input  logic             standby,
  input  logic [SEL_W-1:0] osel,
  output logic             core_en,
  output logic             clk_out
);
  logic pause_s;
  logic int_ph;
  logic ref_ph;

  cpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pause_n), .q_sync(pause_s)
  );

  cpc_phase #(.REF_DIV(REF_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .int_ph(int_ph), .ref_ph(ref_ph)
  );

  cpc_outsel u_sel (
    .int_ph(int_ph), .ref_ph(ref_ph), .standby(standby), .sel(osel), .pin(clk_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) core_en <= 1'b1;
    else        core_en <= pause_s & ~nock;
  end

  // R2
  pause_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_s |=> !core_en);

  // R4
  nock_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nock |=> !core_en);

  // R3
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_s && !nock) |=> core_en);

  // R6
  standby_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && osel == OSEL_GATED) |-> clk_out);

  // R8
  const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osel == OSEL_LO || osel > OSEL_HI) |-> !clk_out);
endmodule

// File: tb/sim_clk_pause_ctl.sv
`timescale 1ns/1ps
module sim_clk_pause_ctl;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pause_n = 1'b1;
  logic       nock = 1'b0;
  logic       standby = 1'b0;
  logic [2:0] osel = 3'd0;
  logic       core_en;
  logic       clk_out;

  int checks = 0;
  int errors = 0;
  int nb = 0;
  int cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_pause_ctl #(.SYNC_STAGES(2), .REF_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .pause_n(pause_n), .nock(nock),
    .standby(standby), .osel(osel), .core_en(core_en), .clk_out(clk_out)
  );

  always @(posedge clk) begin
    if (!rst_n) nb <= 0;
    else        nb <= nb + 1;
    if (rst_n && core_en) cnt <= cnt + 1;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (edge %0d)", req, act, exp, nb);
    end
  endtask

  function automatic logic exp_out(input int k, input logic [2:0] s, input logic sb);
    case (s)
      3'd0: return logic'(k % 2);
      3'd1: return sb ? 1'b1 : logic'(k % 2);
      3'd2: return logic'((k / DIV) % 2);
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic pause_run(input int len);
    int c0;
    @(negedge clk);
    osel = 3'd0;
    pause_n = 1'b0;
    c0 = cnt;
    for (int k = 1; k <= len + 6; k++) begin
      @(negedge clk);
      if (k == len) pause_n = 1'b1;
      if (k == 3) chk("R2", core_en, 1'b0);
      else chk("R3", core_en, !(k >= 3 && k <= len + 2));
      chk("R5", clk_out, exp_out(nb, 3'd0, 1'b0));
    end
    checks++;
    if (cnt - c0 != 6) begin
      errors++;
      $display("FAIL R3: counter advanced %0d expected %0d", cnt - c0, 6);
    end
  endtask

  initial begin
    osel = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1", core_en, 1'b1);
    chk("R1", clk_out, 1'b0);
    osel = 3'd2;
    #1 chk("R1", clk_out, 1'b0);
    osel = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int len = 1; len <= 6; len++) pause_run(len);

    // R4 no-clock bit alone
    @(negedge clk);
    nock = 1'b1;
    @(negedge clk);
    chk("R4", core_en, 1'b0);
    nock = 1'b0;
    @(negedge clk);
    chk("R4", core_en, 1'b1);

    // R4 overlap: pause released while nock still set
    nock = 1'b1;
    pause_n = 1'b0;
    repeat (4) @(negedge clk);
    pause_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R4", core_en, 1'b0);
    end
    nock = 1'b0;
    @(negedge clk);
    chk("R4", core_en, 1'b1);

    // R5..R8 select sweep
    for (int sb = 0; sb < 2; sb++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        osel = 3'(s);
        standby = 1'(sb);
        for (int k = 0; k < 2 * DIV + 1; k++) begin
          #1;
          if (s == 1) chk("R6", clk_out, exp_out(nb, 3'(s), 1'(sb)));
          else if (s == 2) chk("R7", clk_out, exp_out(nb, 3'(s), 1'(sb)));
          else if (s == 0) chk("R5", clk_out, exp_out(nb, 3'(s), 1'(sb)));
          else chk("R8", clk_out, exp_out(nb, 3'(s), 1'(sb)));
          @(negedge clk);
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule